// File: doc/BRIEF.md
# Dual-Port Game Pad Serializer

This block stands in for the serial shift-register game pads that a console polls through its two controller ports. The console raises one shared latch line for both ports, then toggles a separate clock line on each port and reads one button bit per clock from the port's data lines. The host side supplies four parallel button bytes, one for each virtual pad. The block converts them into the bit streams the console expects, most significant bit first.

A two-bit mode input chooses how the four pads appear. In the paired mode each port carries one pad on its first data line. In the wide mode each port also carries a second pad on its second data line, and both lines shift in lockstep. In the chained mode each port sends a 24-bit stream on its first data line: its own pad, then a partner pad, then a fixed signature byte that tells the console a four-pad adapter is present. The latch and the port clocks are asynchronous to the system clock. Each is synchronized and edge-detected before it has any effect.

Top module: `pad_port_shifter`

## Requirements
- R1: After reset all four data outputs are high, and they stay high while port clock edges arrive before the first latch.
- R2: A latch rising edge restarts both ports at stream position 0. Each port's first data line then shows bit 7 of that port's first byte (port 0: pad 0, port 1: pad 1). The pad byte for pad k is `padBytes[8k+7:8k]`.
- R3: Each rising edge on a port's clock after a latch moves that port one position further, from bit 7 down to bit 0 within each byte.
- R4: Mode `2'b00` (and the spare code `2'b11`): port p sends pad p on its first data line for 8 positions and low after that. Both second data lines stay high.
- R5: Mode `2'b01`: the second data line of port p carries pad p+2 in lockstep with the first line. Both lines are low after 8 positions.
- R6: Mode `2'b10`: the first data line of port 0 sends pad 0, pad 2, then 8'hEF. The first data line of port 1 sends pad 1, pad 3, then 8'hDF. Each byte starts again at bit 7. Both second data lines stay high.
- R7: Once a port's stream is used up (8 positions, or 24 in mode `2'b10`), any number of further clock edges keeps its data lines low until the next latch.
- R8: A clock edge on one port never moves the other port's position.
- R9: If a latch edge and a port clock edge are detected in the same system cycle, the latch wins and the port restarts at position 0.
- R10: The pad bytes and the mode are captured at the latch edge. Later changes to them have no effect on the stream until the next latch.
- R11: A rising input edge changes the data outputs at the third rising system clock edge after the input goes high. The outputs are unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Stream mode: 00 paired, 01 wide, 10 chained, 11 as paired |
| padBytes | input | 32 | Four button bytes, pad k at bits 8k+7 down to 8k |
| latchIn | input | 1 | Shared asynchronous latch from the console |
| portClkIn | input | 2 | Asynchronous per-port shift clocks, bit p for port p |
| d0Out | output | 2 | First data line of each port |
| d1Out | output | 2 | Second data line of each port |

## Verification
The position counter, the captured mode and the held pad bytes are visible only through the bits the ports emit, so a fault in any of them shows up within one port clock pulse of the latch. A counter that wraps instead of saturating makes a data line go high again once the stream is used up. A counter shared between ports shows up as a skipped bit on the idle port the next time that port is sampled. Missing captures show up as a changed bit in the cycle after the host rewrites its bytes mid-stream. A lost latch priority leaves bit 6 where bit 7 should be.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int PORTS     = 2;
  localparam int PADS      = 2 * PORTS;
  localparam int BYTE_W    = 8;
  localparam int CHAIN_LEN = 3;
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int POS_W     = $clog2(BYTE_W * CHAIN_LEN + 1);

  typedef enum logic [1:0] {
    MODE_PAIR  = 2'b00,
    MODE_WIDE  = 2'b01,
    MODE_CHAIN = 2'b10,
    MODE_SPARE = 2'b11
  } modeT;

  typedef struct packed {
    logic                         load;
    logic [PORTS-1:0]             step;
    logic [PORTS-1:0][POS_W-1:0]  pos;
    modeT                         mode;
  } strobeT;
endpackage

// File: rtl/pss_edge_sync.sv
module pss_edge_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] rise
);
  logic [STAGES:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rstN) stg <= '0;
    else       stg[0] <= asyncIn;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stg[k] <= '0;
      else       stg[k] <= stg[k-1];
    end
  end

  assign rise = stg[STAGES-1] & ~stg[STAGES];
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             latchRise,
  input  logic [PORTS-1:0] clkRise,
  input  logic [1:0]       modeSel,
  output strobeT           strb
);
  localparam logic [POS_W-1:0] LIM_SHORT = POS_W'(BYTE_W);
  localparam logic [POS_W-1:0] LIM_LONG  = POS_W'(BYTE_W * CHAIN_LEN);

  modeT                        curMode;
  modeT                        effMode;
  logic [PORTS-1:0]            primed;
  logic [PORTS-1:0][POS_W-1:0] pos;
  logic [PORTS-1:0][POS_W-1:0] nextPos;
  logic [PORTS-1:0]            stepNow;
  logic [POS_W-1:0]            limit;

  always_comb begin
    effMode = latchRise ? modeT'(modeSel) : curMode;
    limit   = (curMode == MODE_CHAIN) ? LIM_LONG : LIM_SHORT;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_comb begin
      stepNow[p] = clkRise[p] & primed[p] & ~latchRise;
      if (latchRise)                      nextPos[p] = '0;
      else if (stepNow[p] && pos[p] < limit) nextPos[p] = pos[p] + POS_W'(1);
      else                                nextPos[p] = pos[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pos[p]    <= '0;
        primed[p] <= 1'b0;
      end else begin
        pos[p] <= nextPos[p];
        if (latchRise) primed[p] <= 1'b1;
      end
    end

    p_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
      latchRise |=> pos[p] == '0);

    p_saturate_r7: assert property (@(posedge clk) disable iff (!rstN)
      (stepNow[p] && pos[p] == limit) |=> pos[p] == $past(pos[p]));

    p_no_cross_r8: assert property (@(posedge clk) disable iff (!rstN)
      (!latchRise && !clkRise[p]) |=> $stable(pos[p]));

    p_latch_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      (latchRise && clkRise[p]) |=> pos[p] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          curMode <= MODE_PAIR;
    else if (latchRise) curMode <= modeT'(modeSel);
  end

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    !latchRise |=> curMode == $past(curMode));

  always_comb begin
    strb.load = latchRise;
    strb.step = stepNow;
    strb.pos  = nextPos;
    strb.mode = effMode;
  end
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter logic [PORTS*BYTE_W-1:0] SIG_WORD = 16'hDFEF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strb,
  input  logic [PADS*BYTE_W-1:0]   padBytes,
  output logic [PORTS-1:0]         d0Out,
  output logic [PORTS-1:0]         d1Out
);
  localparam logic [POS_W-1:0] LIM_SHORT = POS_W'(BYTE_W);
  localparam logic [POS_W-1:0] LIM_LONG  = POS_W'(BYTE_W * CHAIN_LEN);

  logic [PADS-1:0][BYTE_W-1:0] heldPads;
  logic [PADS-1:0][BYTE_W-1:0] srcPads;
  logic [PORTS-1:0]            d0Nxt;
  logic [PORTS-1:0]            d1Nxt;
  logic                        seenLoad;

  assign srcPads = strb.load ? padBytes : heldPads;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldPads <= '0;
      seenLoad <= 1'b0;
    end else if (strb.load) begin
      heldPads <= padBytes;
      seenLoad <= 1'b1;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [POS_W-1:0]       posNow;
    logic [BIT_W-1:0]       bitIdx;
    logic [POS_W-BIT_W-1:0] byteIdx;
    logic [POS_W-1:0]       lim;
    logic [BYTE_W-1:0]      sigByte;

    assign sigByte = SIG_WORD[p*BYTE_W +: BYTE_W];

    always_comb begin
      posNow  = strb.pos[p];
      bitIdx  = BIT_W'(BYTE_W - 1) - posNow[BIT_W-1:0];
      byteIdx = posNow[POS_W-1:BIT_W];
      lim     = (strb.mode == MODE_CHAIN) ? LIM_LONG : LIM_SHORT;

      if (posNow >= lim) begin
        d0Nxt[p] = 1'b0;
      end else begin
        case (byteIdx)
          '0:      d0Nxt[p] = srcPads[p][bitIdx];
          1:       d0Nxt[p] = srcPads[p+PORTS][bitIdx];
          default: d0Nxt[p] = sigByte[bitIdx];
        endcase
      end

      if (strb.mode == MODE_WIDE)
        d1Nxt[p] = (posNow < LIM_SHORT) ? srcPads[p+PORTS][bitIdx] : 1'b0;
      else
        d1Nxt[p] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        d0Out[p] <= 1'b1;
        d1Out[p] <= 1'b1;
      end else if (strb.load || strb.step[p]) begin
        d0Out[p] <= d0Nxt[p];
        d1Out[p] <= d1Nxt[p];
      end
    end

    p_d1_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
      ((strb.load || strb.step[p]) && strb.mode != MODE_WIDE) |=> d1Out[p]);

    p_tail_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strb.step[p] && strb.pos[p] >= LIM_LONG) |=> (!d0Out[p]));

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.load && !strb.step[p]) |=> ($stable(d0Out[p]) && $stable(d1Out[p])));
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !seenLoad |-> (&d0Out && &d1Out));
endmodule

// File: rtl/pad_port_shifter.sv
module pad_port_shifter
  import pss_pkg::*;
#(
  parameter int                      SYNC_STAGES = 2,
  parameter logic [PORTS*BYTE_W-1:0] SIG_WORD    = 16'hDFEF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modeSel,
  input  logic [PADS*BYTE_W-1:0]   padBytes,
  input  logic                     latchIn,
  input  logic [PORTS-1:0]         portClkIn,
  output logic [PORTS-1:0]         d0Out,
  output logic [PORTS-1:0]         d1Out
);
  localparam int EDGES = PORTS + 1;

  logic [EDGES-1:0] riseVec;
  strobeT           strb;

  pss_edge_sync #(.N(EDGES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({portClkIn, latchIn}),
    .rise    (riseVec)
  );

  pss_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .latchRise (riseVec[0]),
    .clkRise   (riseVec[EDGES-1:1]),
    .modeSel   (modeSel),
    .strb      (strb)
  );

  pss_datapath #(.SIG_WORD(SIG_WORD)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .padBytes (padBytes),
    .d0Out    (d0Out),
    .d1Out    (d1Out)
  );
endmodule

// File: tb/sim_pad_port_shifter.sv
module sim_pad_port_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [31:0] padBytes = '0;
  logic        latchIn = 1'b0;
  logic [1:0]  portClkIn = 2'b00;
  logic [1:0]  d0Out, d1Out;

  int checks = 0;
  int errors = 0;

  // {mode, pads}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'b00, 32'h3C5A_A596},
    {2'b01, 32'h0FF0_81C3},
    {2'b10, 32'h1234_ABCD},
    {2'b10, 32'hFFFF_FFFF},
    {2'b11, 32'h00FF_7E01},
    {2'b01, 32'hC35A_6699}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_port_shifter u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .padBytes(padBytes),
    .latchIn(latchIn), .portClkIn(portClkIn), .d0Out(d0Out), .d1Out(d1Out)
  );

  function automatic logic expBit(logic [1:0] mode, logic [31:0] pads,
                                  int port, int pos, int line);
    logic [7:0] b;
    int len;
    if (line == 1) begin
      if (mode != 2'b01) return 1'b1;
      if (pos >= 8) return 1'b0;
      b = pads[(port+2)*8 +: 8];
      return b[7 - pos];
    end
    len = (mode == 2'b10) ? 24 : 8;
    if (pos >= len) return 1'b0;
    case (pos / 8)
      0:       b = pads[port*8 +: 8];
      1:       b = pads[(port+2)*8 +: 8];
      default: b = (port == 1) ? 8'hDF : 8'hEF;
    endcase
    return b[7 - (pos % 8)];
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic checkPorts(string req, logic [1:0] mode, logic [31:0] pads,
                            int pos0, int pos1);
    check(req, d0Out[0], expBit(mode, pads, 0, pos0, 0));
    check(req, d0Out[1], expBit(mode, pads, 1, pos1, 0));
    check(req, d1Out[0], expBit(mode, pads, 0, pos0, 1));
    check(req, d1Out[1], expBit(mode, pads, 1, pos1, 1));
  endtask

  task automatic pulseClk(logic [1:0] which);
    @(negedge clk) portClkIn = which;
    repeat (4) @(negedge clk);
    portClkIn = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseLatch();
    @(negedge clk) latchIn = 1'b1;
    repeat (4) @(negedge clk);
    latchIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 d0 reset", &d0Out, 1'b1);
    check("R1 d1 reset", &d1Out, 1'b1);
    // R1: clocks before first latch are ignored
    pulseClk(2'b11);
    pulseClk(2'b01);
    check("R1 d0 pre-latch", &d0Out, 1'b1);
    check("R1 d1 pre-latch", &d1Out, 1'b1);

    // R11 and R2: latency of a latch edge
    modeSel  = 2'b00;
    padBytes = 32'h0000_0000;
    @(negedge clk) latchIn = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) check("R11 unchanged after two edges", d0Out[0], 1'b1);
    @(posedge clk);
    @(negedge clk) check("R11 R2 changed after three edges", d0Out[0], 1'b0);
    repeat (4) @(negedge clk);
    latchIn = 1'b0;
    repeat (4) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  m;
      logic [31:0] pd;
      string tag;
      m  = VEC[v][33:32];
      pd = VEC[v][31:0];
      tag = (m == 2'b01) ? "R5 wide" : (m == 2'b10) ? "R6 chain" : "R4 pair";
      modeSel  = m;
      padBytes = pd;
      pulseLatch();
      checkPorts("R2 first bit", m, pd, 0, 0);
      for (int k = 1; k <= 28; k++) begin
        pulseClk(2'b11);
        if (k >= ((m == 2'b10) ? 24 : 8)) checkPorts("R7 tail low", m, pd, k, k);
        else                              checkPorts({"R3 ", tag}, m, pd, k, k);
      end
    end

    // R7: many extra pulses keep the lines low
    modeSel = 2'b10; padBytes = 32'hFFFF_FFFF;
    pulseLatch();
    for (int k = 0; k < 40; k++) pulseClk(2'b11);
    checkPorts("R7 saturated", 2'b10, 32'hFFFF_FFFF, 40, 40);

    // R8: ports independent
    modeSel = 2'b00; padBytes = 32'h0000_A55A;
    pulseLatch();
    pulseClk(2'b01); pulseClk(2'b01); pulseClk(2'b01);
    checkPorts("R8 port1 untouched", 2'b00, 32'h0000_A55A, 3, 0);
    pulseClk(2'b10);
    checkPorts("R8 port0 untouched", 2'b00, 32'h0000_A55A, 3, 1);

    // R9: latch and clocks in the same cycle
    modeSel = 2'b01; padBytes = 32'h4080_C040;
    pulseLatch();
    pulseClk(2'b11); pulseClk(2'b11);
    @(negedge clk) begin latchIn = 1'b1; portClkIn = 2'b11; end
    repeat (4) @(negedge clk);
    latchIn = 1'b0; portClkIn = 2'b00;
    repeat (4) @(negedge clk);
    checkPorts("R9 latch wins", 2'b01, 32'h4080_C040, 0, 0);
    pulseClk(2'b11);
    checkPorts("R9 next bit", 2'b01, 32'h4080_C040, 1, 1);

    // R10: inputs rewritten mid-stream have no effect
    modeSel = 2'b10; padBytes = 32'h5AA5_3CC3;
    pulseLatch();
    for (int k = 1; k <= 10; k++) begin
      pulseClk(2'b11);
      if (k == 3) begin modeSel = 2'b01; padBytes = ~32'h5AA5_3CC3; end
      checkPorts("R10 captured", 2'b10, 32'h5AA5_3CC3, k, k);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule